// File: doc/BRIEF.md
# Upper Address Byte Slice with Board Glue

This block is the upper slice of an 8-bit processor whose address path is split over separate parts. It owns the upper byte of the program counter and drives the upper 8 bits of the address bus. Each cycle it takes the same 5-bit address operation code that the lower slice receives, along with two carry bits from that slice. One carry belongs to the address sum and the other to the program-counter sum. The operation code selects which carry to use, so a page crossing is absorbed in the same cycle that the lower byte is formed. No extra cycle is spent on it.

The slice takes upper address bytes from the data bus for absolute and jump targets. It forces page 0x00 for zero-page accesses, page 0x01 for stack accesses and page 0xFF for vector fetches. During call and interrupt pushes it drives the program-counter upper byte onto the data bus. Because the slice is small, it also holds the board glue. It decodes active-low selects for RAM, an I/O window and ROM from the new upper address byte. It also divides the system clock by an even ratio with a 50% duty cycle.

Top module: `addr_hi_slice`

## Requirements
- R1: While `rst` is high at a clock edge, `ab_hi_o` becomes 0xFF, `db_oe` becomes 0, `clk_div_o` becomes 0 and the internal program-counter upper byte becomes 0x00. The select outputs then show the ROM range (`cs_rom_n`=0, the other two 1).
- R2: Operation code 1 (fetch) adds `pc_carry_i` to the program-counter upper byte modulo 256. It also places the new value on `ab_hi_o` after the same clock edge.
- R3: Operation code 4 (absolute) sets `ab_hi_o` to `db_i` + `adr_carry_i` modulo 256 and leaves the program counter unchanged.
- R4: Operation code 5 (jump) loads `db_i` into the program-counter upper byte and onto `ab_hi_o`.
- R5: Operation codes 2 (zero page), 3 (stack) and 7 (vector) set `ab_hi_o` to 0x00, 0x01 and 0xFF respectively. None of them changes the program counter.
- R6: Operation code 6 (push) sets `ab_hi_o` to 0x01. For that cycle only, it drives `db_o` with the program-counter upper byte and raises `db_oe`. The program counter keeps its value.
- R7: Operation code 8 (pointer step) adds `adr_carry_i` to the current `ab_hi_o` modulo 256.
- R8: Operation code 0 and every code from 9 to 31 leave `ab_hi_o` and the program counter unchanged. Under any code other than 6, `db_oe` is 0 after the edge.
- R9: The selects are active low and are decoded from the new `ab_hi_o` in the same cycle. `cs_ram_n` covers 0x00–0x7F, `cs_io_n` covers 0xD0–0xDF and `cs_rom_n` covers 0xE0–0xFF. No select is active for 0x80–0xCF, and at most one select is active at any time.
- R10: After reset is released, `clk_div_o` toggles every `CLK_DIV`/2 clock edges, so with the default of 4 it reads (k/2) mod 2 after k edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Address operation code shared with the lower slice |
| adr_carry_i | input | 1 | Carry out of the lower slice's address sum |
| pc_carry_i | input | 1 | Carry out of the lower slice's program-counter sum |
| db_i | input | 8 | Data bus input |
| db_o | output | 8 | Data bus output (program-counter upper byte) |
| db_oe | output | 1 | Data bus drive enable |
| ab_hi_o | output | 8 | Upper address byte |
| cs_ram_n | output | 1 | RAM select, active low |
| cs_io_n | output | 1 | I/O window select, active low |
| cs_rom_n | output | 1 | ROM select, active low |
| clk_div_o | output | 1 | Divided clock |

## Verification
All results are registered and are due one clock edge after the operation code is applied. This holds for the new `ab_hi_o` and the three selects decoded from it, for the pushed byte on `db_o` together with `db_oe`, and for the new divider level. The bench drives each stimulus 1 ns after a rising edge and advances its reference model on the next rising edge. It compares every output 1 ns later, well before the following edge. The program counter has no port of its own. Its value is checked through the address that a later fetch or push produces.

// File: rtl/ahi_pkg.sv
package ahi_pkg;
  localparam int AOP_W = 5;

  typedef enum logic [AOP_W-1:0] {
    AOP_HOLD  = 5'd0,
    AOP_FETCH = 5'd1,
    AOP_ZPG   = 5'd2,
    AOP_STK   = 5'd3,
    AOP_ABS   = 5'd4,
    AOP_JUMP  = 5'd5,
    AOP_PUSH  = 5'd6,
    AOP_VEC   = 5'd7,
    AOP_INC   = 5'd8
  } aop_e;
endpackage

// File: rtl/ahi_pc_reg.sv
module ahi_pc_reg
  import ahi_pkg::*;
#(
  parameter int          W      = 8,
  parameter logic [W-1:0] PC_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  aop_e         op,
  input  logic         pc_carry,
  input  logic [W-1:0] db_i,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] pc_next
);
  always_comb begin
    case (op)
      AOP_FETCH: pc_next = pc_q + W'(pc_carry);
      AOP_JUMP:  pc_next = db_i;
      default:   pc_next = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= PC_RST;
    else     pc_q <= pc_next;
  end
endmodule

// File: rtl/ahi_addr_mux.sv
module ahi_addr_mux
  import ahi_pkg::*;
#(
  parameter int           W      = 8,
  parameter logic [W-1:0] AB_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  aop_e         op,
  input  logic         adr_carry,
  input  logic [W-1:0] db_i,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] pc_next,
  output logic [W-1:0] ab_next,
  output logic [W-1:0] ab_q,
  output logic [W-1:0] db_o,
  output logic         db_oe
);
  localparam logic [W-1:0] ZERO_PAGE  = '0;
  localparam logic [W-1:0] STACK_PAGE = W'(1);
  localparam logic [W-1:0] VEC_PAGE   = '1;

  always_comb begin
    case (op)
      AOP_FETCH: ab_next = pc_next;
      AOP_ZPG:   ab_next = ZERO_PAGE;
      AOP_STK:   ab_next = STACK_PAGE;
      AOP_ABS:   ab_next = db_i + W'(adr_carry);
      AOP_JUMP:  ab_next = pc_next;
      AOP_PUSH:  ab_next = STACK_PAGE;
      AOP_VEC:   ab_next = VEC_PAGE;
      AOP_INC:   ab_next = ab_q + W'(adr_carry);
      default:   ab_next = ab_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q  <= AB_RST;
      db_o  <= '0;
      db_oe <= 1'b0;
    end else begin
      ab_q  <= ab_next;
      db_oe <= (op == AOP_PUSH);
      if (op == AOP_PUSH) db_o <= pc_q;
    end
  end
endmodule

// File: rtl/ahi_cs_decode.sv
module ahi_cs_decode #(
  parameter int           W         = 8,
  parameter logic [W-1:0] AB_RST    = '1,
  parameter logic [W-1:0] RAM_LAST  = 8'h7F,
  parameter logic [W-1:0] IO_FIRST  = 8'hD0,
  parameter logic [W-1:0] IO_LAST   = 8'hDF,
  parameter logic [W-1:0] ROM_FIRST = 8'hE0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ab_next,
  output logic         cs_ram_n,
  output logic         cs_io_n,
  output logic         cs_rom_n
);
  // returns {ram, io, rom} active-high hits
  function automatic logic [2:0] hits(input logic [W-1:0] a);
    logic ram, io, rom;
    ram = (a <= RAM_LAST);
    io  = (a >= IO_FIRST) && (a <= IO_LAST);
    rom = (a >= ROM_FIRST);
    return {ram, io & ~ram, rom & ~ram & ~io};
  endfunction

  localparam logic [2:0] RST_HITS = hits(AB_RST);

  always_ff @(posedge clk) begin
    if (rst) {cs_ram_n, cs_io_n, cs_rom_n} <= ~RST_HITS;
    else     {cs_ram_n, cs_io_n, cs_rom_n} <= ~hits(ab_next);
  end
endmodule

// File: rtl/ahi_clk_div.sv
module ahi_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic clk_div
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (HALF == 1) begin : g_toggle
      always_ff @(posedge clk) begin
        if (rst) clk_div <= 1'b0;
        else     clk_div <= ~clk_div;
      end
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt     <= '0;
          clk_div <= 1'b0;
        end else if (cnt == LAST) begin
          cnt     <= '0;
          clk_div <= ~clk_div;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/addr_hi_slice.sv
module addr_hi_slice
  import ahi_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          CLK_DIV   = 4,
  parameter logic [7:0]  RESET_AB  = 8'hFF,
  parameter logic [7:0]  RESET_PC  = 8'h00,
  parameter logic [7:0]  RAM_LAST  = 8'h7F,
  parameter logic [7:0]  IO_FIRST  = 8'hD0,
  parameter logic [7:0]  IO_LAST   = 8'hDF,
  parameter logic [7:0]  ROM_FIRST = 8'hE0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op_i,
  input  logic          adr_carry_i,
  input  logic          pc_carry_i,
  input  logic [DW-1:0] db_i,
  output logic [DW-1:0] db_o,
  output logic          db_oe,
  output logic [DW-1:0] ab_hi_o,
  output logic          cs_ram_n,
  output logic          cs_io_n,
  output logic          cs_rom_n,
  output logic          clk_div_o
);
  aop_e          op;
  logic [DW-1:0] pc_q, pc_next, ab_next;

  assign op = aop_e'(op_i);

  ahi_pc_reg #(.W(DW), .PC_RST(DW'(RESET_PC))) u_pc (
    .clk(clk), .rst(rst), .op(op), .pc_carry(pc_carry_i), .db_i(db_i),
    .pc_q(pc_q), .pc_next(pc_next)
  );

  ahi_addr_mux #(.W(DW), .AB_RST(DW'(RESET_AB))) u_mux (
    .clk(clk), .rst(rst), .op(op), .adr_carry(adr_carry_i), .db_i(db_i),
    .pc_q(pc_q), .pc_next(pc_next), .ab_next(ab_next), .ab_q(ab_hi_o),
    .db_o(db_o), .db_oe(db_oe)
  );

  ahi_cs_decode #(
    .W(DW), .AB_RST(DW'(RESET_AB)), .RAM_LAST(DW'(RAM_LAST)),
    .IO_FIRST(DW'(IO_FIRST)), .IO_LAST(DW'(IO_LAST)), .ROM_FIRST(DW'(ROM_FIRST))
  ) u_cs (
    .clk(clk), .rst(rst), .ab_next(ab_next),
    .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n), .cs_rom_n(cs_rom_n)
  );

  ahi_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .clk_div(clk_div_o)
  );
endmodule

// File: rtl/addr_hi_slice_chk.sv
module addr_hi_slice_chk
  import ahi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [4:0] op_i,
  input logic [7:0] ab_hi_o,
  input logic       db_oe,
  input logic       cs_ram_n,
  input logic       cs_io_n,
  input logic       cs_rom_n
);
  // R5
  zero_page_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == AOP_ZPG |=> ab_hi_o == 8'h00);
  // R5
  stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == AOP_STK |=> ab_hi_o == 8'h01);
  // R6
  push_drive_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == AOP_PUSH |=> db_oe && ab_hi_o == 8'h01);
  // R8
  no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    op_i != AOP_PUSH |=> !db_oe);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    op_i == AOP_HOLD |=> $stable(ab_hi_o));
  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~cs_ram_n, ~cs_io_n, ~cs_rom_n}));
endmodule

bind addr_hi_slice addr_hi_slice_chk u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .ab_hi_o(ab_hi_o), .db_oe(db_oe),
  .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n), .cs_rom_n(cs_rom_n)
);

// File: tb/addr_hi_slice_test.sv
module addr_hi_slice_test;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic       adr_carry_i = 1'b0, pc_carry_i = 1'b0;
  logic [7:0] db_i = '0;
  logic [7:0] db_o, ab_hi_o;
  logic       db_oe, cs_ram_n, cs_io_n, cs_rom_n, clk_div_o;

  int total = 0, bad = 0, k = 0;
  logic [7:0] e_ab, e_pc, e_dbo;
  logic       e_oe;

  always #2 clk = ~clk;

  addr_hi_slice uut (
    .clk(clk), .rst(rst), .op_i(op_i), .adr_carry_i(adr_carry_i),
    .pc_carry_i(pc_carry_i), .db_i(db_i), .db_o(db_o), .db_oe(db_oe),
    .ab_hi_o(ab_hi_o), .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n),
    .cs_rom_n(cs_rom_n), .clk_div_o(clk_div_o)
  );

  // expected {ram_n, io_n, rom_n}
  function automatic logic [2:0] sel_n(input logic [7:0] a);
    if (a <= 8'h7F) return 3'b011;
    if (a >= 8'hD0 && a <= 8'hDF) return 3'b101;
    if (a >= 8'hE0) return 3'b110;
    return 3'b111;
  endfunction

  function automatic string tag(input logic [4:0] op);
    case (op)
      5'd1: return "R2";
      5'd4: return "R3";
      5'd5: return "R4";
      5'd2, 5'd3, 5'd7: return "R5";
      5'd6: return "R6";
      5'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "ab_hi_o", ab_hi_o, e_ab);
    chk("R9", "selects", {cs_ram_n, cs_io_n, cs_rom_n}, sel_n(e_ab));
    chk(e_oe ? "R6" : "R8", "db_oe", db_oe, e_oe);
    if (e_oe) chk("R6", "db_o", db_o, e_dbo);
    chk("R10", "clk_div_o", clk_div_o, (k / HALF) % 2);
  endtask

  task automatic step(input logic [4:0] op, input logic [7:0] d,
                      input logic ac, input logic pcc);
    logic [7:0] old_pc;
    op_i = op; db_i = d; adr_carry_i = ac; pc_carry_i = pcc;
    @(posedge clk);
    old_pc = e_pc;
    case (op)
      5'd1: begin e_pc = e_pc + 8'(pcc); e_ab = e_pc; end
      5'd2: e_ab = 8'h00;
      5'd3: e_ab = 8'h01;
      5'd4: e_ab = d + 8'(ac);
      5'd5: begin e_pc = d; e_ab = d; end
      5'd6: begin e_ab = 8'h01; e_dbo = old_pc; end
      5'd7: e_ab = 8'hFF;
      5'd8: e_ab = e_ab + 8'(ac);
      default: ;
    endcase
    e_oe = (op == 5'd6);
    k++;
    #1;
    check_all(tag(op));
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    e_ab = 8'hFF; e_pc = 8'h00; e_oe = 1'b0; e_dbo = 8'h00;
    // R1 reset state
    chk("R1", "ab_hi_o", ab_hi_o, 8'hFF);
    chk("R1", "db_oe", db_oe, 0);
    chk("R1", "clk_div_o", clk_div_o, 0);
    chk("R1", "selects", {cs_ram_n, cs_io_n, cs_rom_n}, 3'b110);
    rst = 1'b0;
    k = 0;
    // R1 program counter reset to 0x00, seen through a fetch
    step(5'd1, 8'h00, 1'b0, 1'b0);
    // R2 wrap of program counter from 0xFF
    step(5'd5, 8'hFF, 1'b0, 1'b0);
    step(5'd1, 8'h00, 1'b1, 1'b1);
    // R6 push of program counter upper byte, then drive released
    step(5'd6, 8'h00, 1'b0, 1'b0);
    step(5'd0, 8'h00, 1'b0, 1'b0);
    // R3 absolute with carry wrap
    step(5'd4, 8'hFF, 1'b1, 1'b0);
    // R9 select boundaries
    step(5'd4, 8'h7F, 1'b0, 1'b0);
    step(5'd4, 8'h7F, 1'b1, 1'b0);
    step(5'd4, 8'hCF, 1'b0, 1'b0);
    step(5'd4, 8'hCF, 1'b1, 1'b0);
    step(5'd4, 8'hDF, 1'b0, 1'b0);
    step(5'd4, 8'hDF, 1'b1, 1'b0);
    // R7 pointer step across 0xFF
    step(5'd7, 8'h00, 1'b0, 1'b0);
    step(5'd8, 8'h00, 1'b1, 1'b0);
    // R8 unused codes keep state
    step(5'd31, 8'hAA, 1'b1, 1'b1);
    step(5'd9, 8'h55, 1'b1, 1'b1);
    // R4 jump then fetch without carry shows unchanged PC
    step(5'd5, 8'hD3, 1'b1, 1'b1);
    step(5'd2, 8'h12, 1'b1, 1'b1);
    step(5'd1, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      op = ($urandom % 4 == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 8));
      step(op, 8'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule